// File: doc/BRIEF.md
# Streaming SHA-256 Hasher

This block turns a byte stream into SHA-256 digests. Bytes arrive one per accepted transfer on a valid/ready stream input with a last-byte marker and a user tag. The block packs them big-endian into 512-bit blocks and appends the 0x80 marker, the zero fill and the 64-bit bit length itself. It runs the 64-round compression at one round per clock, and the chaining value is carried from block to block within a message.

When a message has been hashed, the block raises a single-cycle output strobe. On that cycle it presents the 256-bit digest, the message length in bytes and the tag that came with the first byte. The output has no backpressure. The input is held off only while the padding of a just-finished message is being generated. A following message can start as soon as ready returns, while the earlier digest is still being computed.

Top module: `sha256_stream`

## Requirements
- R1: A byte is taken only on a clock edge where tvalid and tready are both 1. Cycles with tvalid=0 can fall anywhere inside a message, and they change nothing, whatever tdata and tlast carry on those cycles.
- R2: Each message ends with the byte that carries tlast=1 and produces exactly one digest. The digest is announced by ovalid, which is high for one cycle only. Digests leave in the order their messages arrived.
- R3: Padding appends byte 0x80, then zero bytes until the block position is 56 mod 64, then the bit length as a 64-bit big-endian value. When 56 or more bytes of the last block are already used, the padding spills into one extra block.
- R4: tready is 1 from reset and while a message is being received. It is 0 from the cycle after the tlast byte is accepted until that message's final block has entered compression.
- R5: osha is the SHA-256 digest of the message, with the first hash word in osha[255:224] and the last in osha[31:0]. Within each 32-bit message word, the first byte received is the most significant.
- R6: olen equals the number of bytes accepted for the message.
- R7: oid equals the tid sampled with the first byte of the message. tid has no effect on any later byte of the same message.
- R8: A new message may start as soon as tready is 1 again, without waiting for ovalid. Every message starts from the standard initial hash value.
- R9: Messages longer than one block chain the compressed value from each block into the next. Bytes can arrive back to back with no input stall in the middle of a message.
- R10: After reset, tready=1 and ovalid=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tvalid | input | 1 | A byte is offered on tdata |
| tready | output | 1 | Block can take a byte this cycle |
| tdata | input | 8 | Message byte |
| tlast | input | 1 | Marks the final byte of a message |
| tid | input | ID_W | Message tag, sampled with the first byte |
| ovalid | output | 1 | Single-cycle digest strobe |
| osha | output | 256 | SHA-256 digest |
| olen | output | LEN_W | Message length in bytes |
| oid | output | ID_W | Tag of the hashed message |

## Verification
The stimulus uses two fixed vectors with known digests. The three-byte one exercises the single-block path. The 56-byte one can only match if the padding spills into a second block. Lengths of 1, 2, 55, 63, 64, 65, 119, 120, 128 and 200 bytes put the tlast byte on each side of the 56-byte and 64-byte boundaries, and each length is checked against an independent software model. The same content is sent both gap-free and with idle cycles that carry junk on tdata and tlast, which shows whether those cycles are truly ignored. Messages are also started the moment tready returns, with later bytes carrying a wrong tid, so a reused chaining value, a late tag capture or a lost digest shows up in the scoreboard order.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

   typedef logic [31:0]       word_t;
   // index 7 holds working word a / first hash word, index 0 holds h
   typedef logic [7:0][31:0]  state_t;

   localparam int BLK_BITS  = 512;
   localparam int BLK_BYTES = BLK_BITS / 8;
   localparam int ROUNDS    = 64;

   function automatic word_t rotr(input word_t x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   function automatic word_t cap_sig0(input word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t cap_sig1(input word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   function automatic word_t low_sig0(input word_t x);
      return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
   endfunction

   function automatic word_t low_sig1(input word_t x);
      return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
   endfunction

   function automatic state_t init_state();
      state_t s;
      s[7] = 32'h6a09e667; s[6] = 32'hbb67ae85;
      s[5] = 32'h3c6ef372; s[4] = 32'ha54ff53a;
      s[3] = 32'h510e527f; s[2] = 32'h9b05688c;
      s[1] = 32'h1f83d9ab; s[0] = 32'h5be0cd19;
      return s;
   endfunction

   function automatic word_t round_k(input logic [5:0] idx);
      word_t k;
      case (idx)
         6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491;
         6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
         6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1;
         6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
         6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01;
         6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
         6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe;
         6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
         6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786;
         6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
         6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa;
         6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
         6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d;
         6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
         6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147;
         6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
         6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138;
         6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
         6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb;
         6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
         6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b;
         6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
         6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624;
         6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
         6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08;
         6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
         6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a;
         6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
         6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f;
         6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
         6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb;
         6'd62: k = 32'hbef9a3f7;
         default: k = 32'hc67178f2;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/sha256_collect.sv
module sha256_collect
   import sha256_pkg::*;
#(
   parameter int LEN_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                take_i,
   input  logic [7:0]          byte_i,
   input  logic                last_i,
   output logic                padding_o,
   output logic                blk_v_o,
   output logic [BLK_BITS-1:0] blk_o,
   output logic                blk_first_o,
   output logic                blk_last_o,
   output logic [LEN_W-1:0]    msg_len_o
);

   localparam int POS_W = $clog2(BLK_BYTES);
   localparam int LEN_POS = BLK_BYTES - 8;

   logic [POS_W-1:0]    pos_q;
   logic [BLK_BITS-1:0] blk_q;
   logic [BLK_BITS-1:0] blk_cur;
   logic [LEN_W-1:0]    len_q;
   logic                pad_q, mark_q, spill_q, first_q;
   logic                push, len_zone, boundary, final_push;
   logic [7:0]          pad_byte, push_byte;
   logic [63:0]         bit_len;
   logic [8:0]          byte_lo;

   assign bit_len    = 64'(len_q) << 3;
   assign len_zone   = mark_q && !spill_q && (pos_q >= POS_W'(LEN_POS));
   assign push       = take_i || pad_q;
   assign boundary   = push && (pos_q == POS_W'(BLK_BYTES - 1));
   assign final_push = pad_q && len_zone && boundary;

   always_comb begin
      if (!mark_q)       pad_byte = 8'h80;
      else if (len_zone) pad_byte = bit_len[{~pos_q[2:0], 3'b000} +: 8];
      else               pad_byte = 8'h00;
   end

   assign push_byte = pad_q ? pad_byte : byte_i;
   assign byte_lo   = {~pos_q, 3'b000};

   always_comb begin
      blk_cur = blk_q;
      blk_cur[byte_lo +: 8] = push_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q   <= '0;
         blk_q   <= '0;
         len_q   <= '0;
         pad_q   <= 1'b0;
         mark_q  <= 1'b0;
         spill_q <= 1'b0;
         first_q <= 1'b1;
      end else begin
         if (push) begin
            blk_q <= blk_cur;
            pos_q <= pos_q + 1'b1;
         end
         if (take_i) begin
            len_q <= len_q + 1'b1;
            if (last_i) begin
               pad_q   <= 1'b1;
               mark_q  <= 1'b0;
               spill_q <= 1'b0;
            end
         end
         if (pad_q) begin
            if (!mark_q) mark_q <= 1'b1;
            if (boundary)
               spill_q <= 1'b0;
            else if (!mark_q && pos_q >= POS_W'(LEN_POS))
               spill_q <= 1'b1;
         end
         if (boundary) first_q <= 1'b0;
         if (final_push) begin
            pad_q   <= 1'b0;
            first_q <= 1'b1;
            len_q   <= '0;
         end
      end
   end

   assign padding_o   = pad_q;
   assign blk_v_o     = boundary;
   assign blk_o       = blk_cur;
   assign blk_first_o = first_q;
   assign blk_last_o  = final_push;
   assign msg_len_o   = len_q;

endmodule

// File: rtl/sha256_sched.sv
module sha256_sched
   import sha256_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [BLK_BITS-1:0] blk_i,
   input  logic                step_i,
   output word_t               w_o
);

   localparam int WORDS = BLK_BITS / 32;

   logic [WORDS-1:0][31:0] win_q;
   word_t                  w_new;

   // win_q[WORDS-1] is W[t]; win_q[WORDS-1-j] is W[t+j]
   assign w_new = low_sig1(win_q[WORDS-15]) + win_q[WORDS-10]
                + low_sig0(win_q[WORDS-2])  + win_q[WORDS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_q <= '0;
      else if (load_i)
         win_q <= blk_i;
      else if (step_i)
         win_q <= {win_q[WORDS-2:0], w_new};
   end

   assign w_o = win_q[WORDS-1];

endmodule

// File: rtl/sha256_compress.sv
module sha256_compress
   import sha256_pkg::*;
#(
   parameter int LEN_W = 32,
   parameter int ID_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_i,
   input  logic [BLK_BITS-1:0] blk_i,
   input  logic                first_i,
   input  logic                last_i,
   input  logic [LEN_W-1:0]    len_i,
   input  logic [ID_W-1:0]     id_i,
   output logic                ready_o,
   output logic                dig_v_o,
   output logic [255:0]        dig_o,
   output logic [LEN_W-1:0]    len_o,
   output logic [ID_W-1:0]     id_o
);

   localparam int RND_W = $clog2(ROUNDS);
   localparam logic [RND_W-1:0] RND_END = RND_W'(ROUNDS - 1);

   state_t           wv_q, hq_q, wv_nx, sum, base;
   logic [RND_W-1:0] rnd_q;
   logic             busy_q, last_q, ending;
   logic [LEN_W-1:0] len_q;
   logic [ID_W-1:0]  id_q;
   word_t            w_cur, t1, t2, ch, maj;

   sha256_sched u_sched (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_i),
      .blk_i  (blk_i),
      .step_i (busy_q),
      .w_o    (w_cur)
   );

   assign ch  = (wv_q[3] & wv_q[2]) ^ (~wv_q[3] & wv_q[1]);
   assign maj = (wv_q[7] & wv_q[6]) ^ (wv_q[7] & wv_q[5]) ^ (wv_q[6] & wv_q[5]);
   assign t1  = wv_q[0] + cap_sig1(wv_q[3]) + ch + round_k(rnd_q) + w_cur;
   assign t2  = cap_sig0(wv_q[7]) + maj;

   assign wv_nx = {t1 + t2, wv_q[7], wv_q[6], wv_q[5],
                   wv_q[4] + t1, wv_q[3], wv_q[2], wv_q[1]};

   for (genvar j = 0; j < 8; j++) begin : g_fold
      assign sum[j] = hq_q[j] + wv_nx[j];
   end

   assign ending  = busy_q && (rnd_q == RND_END);
   assign ready_o = !busy_q || ending;

   always_comb begin
      if (first_i)     base = init_state();
      else if (ending) base = sum;
      else             base = hq_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         rnd_q   <= '0;
         wv_q    <= '0;
         hq_q    <= '0;
         last_q  <= 1'b0;
         len_q   <= '0;
         id_q    <= '0;
         dig_v_o <= 1'b0;
         dig_o   <= '0;
         len_o   <= '0;
         id_o    <= '0;
      end else begin
         dig_v_o <= 1'b0;
         if (busy_q) begin
            wv_q  <= wv_nx;
            rnd_q <= rnd_q + 1'b1;
            if (ending) begin
               hq_q   <= sum;
               busy_q <= 1'b0;
               if (last_q) begin
                  dig_v_o <= 1'b1;
                  dig_o   <= sum;
                  len_o   <= len_q;
                  id_o    <= id_q;
               end
            end
         end
         if (load_i) begin
            busy_q <= 1'b1;
            rnd_q  <= '0;
            wv_q   <= base;
            hq_q   <= base;
            last_q <= last_i;
            if (last_i) begin
               len_q <= len_i;
               id_q  <= id_i;
            end
         end
      end
   end

   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      dig_v_o |=> !dig_v_o) else $error("digest strobe longer than one cycle"); // R2
   AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> ready_o) else $error("block handed over while rounds run"); // R9

endmodule

// File: rtl/sha256_stream.sv
module sha256_stream
   import sha256_pkg::*;
#(
   parameter int ID_W  = 8,
   parameter int LEN_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tvalid,
   output logic              tready,
   input  logic [7:0]        tdata,
   input  logic              tlast,
   input  logic [ID_W-1:0]   tid,
   output logic              ovalid,
   output logic [255:0]      osha,
   output logic [LEN_W-1:0]  olen,
   output logic [ID_W-1:0]   oid
);

   initial begin
      assert (ID_W >= 1) else $error("ID_W must be at least 1");
      assert (LEN_W >= 4 && LEN_W <= 61) else $error("LEN_W out of range 4..61");
   end

   logic                take, padding, blk_v, blk_first, blk_last, core_ready;
   logic [BLK_BITS-1:0] blk;
   logic [LEN_W-1:0]    msg_len;
   logic [ID_W-1:0]     tag_q;
   logic                mid_q;

   assign tready = !padding;
   assign take   = tvalid && tready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= '0;
         mid_q <= 1'b0;
      end else if (take) begin
         if (!mid_q) tag_q <= tid;
         mid_q <= !tlast;
      end
   end

   sha256_collect #(.LEN_W(LEN_W)) u_collect (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_i      (take),
      .byte_i      (tdata),
      .last_i      (tlast),
      .padding_o   (padding),
      .blk_v_o     (blk_v),
      .blk_o       (blk),
      .blk_first_o (blk_first),
      .blk_last_o  (blk_last),
      .msg_len_o   (msg_len)
   );

   sha256_compress #(.LEN_W(LEN_W), .ID_W(ID_W)) u_compress (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (blk_v),
      .blk_i   (blk),
      .first_i (blk_first),
      .last_i  (blk_last),
      .len_i   (msg_len),
      .id_i    (tag_q),
      .ready_o (core_ready),
      .dig_v_o (ovalid),
      .dig_o   (osha),
      .len_o   (olen),
      .id_o    (oid)
   );

   AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && tlast) |=> !tready) else $error("tready still high after last byte"); // R4
   AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mid_q) |=> $stable(tag_q)) else $error("tag changed inside message"); // R7
   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      blk_v |-> core_ready) else $error("block arrived before rounds finished"); // R9

endmodule

// File: tb/sha256_stream_tb_top.sv
module sha256_stream_tb_top;
   import sha256_pkg::*;

   localparam int ID_W  = 8;
   localparam int LEN_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tvalid = 1'b0, tlast = 1'b0;
   logic [7:0]       tdata = '0;
   logic [ID_W-1:0]  tid = '0;
   logic             tready, ovalid;
   logic [255:0]     osha;
   logic [LEN_W-1:0] olen;
   logic [ID_W-1:0]  oid;

   int total = 0, bad = 0, sent = 0, got = 0;
   logic [255:0] q_sha[$];
   int           q_len[$];
   logic [ID_W-1:0] q_id[$];
   logic prev_ov = 1'b0;

   always #2 clk = ~clk;

   sha256_stream #(.ID_W(ID_W), .LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .tvalid(tvalid), .tready(tready),
      .tdata(tdata), .tlast(tlast), .tid(tid), .ovalid(ovalid),
      .osha(osha), .olen(olen), .oid(oid)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] rr(input logic [31:0] x, input int n);
      return (x >> n) | (x << (32 - n));
   endfunction

   // independent software model of the hash
   function automatic logic [255:0] model(input logic [7:0] m[$]);
      logic [7:0]  p[$];
      logic [63:0] bl;
      logic [31:0] w [0:63];
      logic [31:0] h [0:7];
      logic [31:0] v [0:7];
      logic [31:0] s0, s1, t1, t2;
      state_t      iv;
      p = m;
      bl = 64'(m.size()) * 64'd8;
      p.push_back(8'h80);
      while ((p.size() % 64) != 56) p.push_back(8'h00);
      for (int i = 7; i >= 0; i--) p.push_back(bl[i*8 +: 8]);
      iv = init_state();
      for (int i = 0; i < 8; i++) h[i] = iv[7-i];
      for (int b = 0; b < p.size() / 64; b++) begin
         for (int t = 0; t < 16; t++)
            w[t] = {p[b*64+t*4], p[b*64+t*4+1], p[b*64+t*4+2], p[b*64+t*4+3]};
         for (int t = 16; t < 64; t++) begin
            s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
            s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
            w[t] = w[t-16] + s0 + w[t-7] + s1;
         end
         for (int i = 0; i < 8; i++) v[i] = h[i];
         for (int t = 0; t < 64; t++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + round_k(6'(t)) + w[t];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
            v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
         end
         for (int i = 0; i < 8; i++) h[i] = h[i] + v[i];
      end
      return {h[0], h[1], h[2], h[3], h[4], h[5], h[6], h[7]};
   endfunction

   function automatic void from_str(input string s, ref logic [7:0] m[$]);
      m.delete();
      for (int i = 0; i < s.len(); i++) m.push_back(s[i]);
   endfunction

   function automatic void from_seed(input int n, input int seed, ref logic [7:0] m[$]);
      m.delete();
      for (int i = 0; i < n; i++) m.push_back(8'(i * 7 + seed));
   endfunction

   // driver: queues the expectation then streams the bytes
   task automatic send(input logic [7:0] m[$], input logic [ID_W-1:0] id,
                       input int gap, input logic [255:0] dig);
      bit stalled = 0;
      q_sha.push_back(dig); q_len.push_back(m.size()); q_id.push_back(id);
      sent++;
      for (int i = 0; i < m.size(); i++) begin
         if (gap > 0 && (i % 3) == 1) begin
            tvalid = 1'b0; tlast = 1'b1; tdata = 8'hA5; tid = 8'h5A;   // R1 junk on idle
            repeat (gap) @(negedge clk);
         end
         tvalid = 1'b1;
         tdata  = m[i];
         tlast  = (i == m.size() - 1);
         tid    = (i == 0) ? id : ~id;                                // R7 later tids differ
         if (i != 0 && !tready) stalled = 1;
         while (!tready) @(negedge clk);
         @(negedge clk);
      end
      tvalid = 1'b0; tlast = 1'b0;
      chk(!stalled, "R9 no stall inside message", 256'(stalled), 0);
      chk(tready == 1'b0, "R4 tready low after tlast", 256'(tready), 0);
      while (!tready) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (ovalid && prev_ov)
            chk(0, "R2 strobe width", 2, 1);
         if (ovalid) begin
            got++;
            if (q_sha.size() == 0) chk(0, "R2 unexpected digest", osha, 0);
            else begin
               logic [255:0] es;
               int el;
               logic [ID_W-1:0] ei;
               es = q_sha.pop_front(); el = q_len.pop_front(); ei = q_id.pop_front();
               chk(osha == es, "R5 digest", osha, es);
               chk(olen == LEN_W'(el), "R6 length", 256'(olen), 256'(el));
               chk(oid == ei, "R7 tag", 256'(oid), 256'(ei));
            end
         end
         prev_ov <= ovalid;
      end
   end

   task automatic finish_up();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (120000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin
      logic [7:0] m[$];
      logic [7:0] m2[$];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tready == 1'b1, "R10 tready after reset", 256'(tready), 1);
      chk(ovalid == 1'b0, "R10 ovalid after reset", 256'(ovalid), 0);

      // R8: two short messages, second starts as soon as tready is back
      from_str("12", m);  send(m, 8'h01, 0, model(m));
      from_str("123", m); send(m, 8'h02, 0, model(m));
      // R5 known answer, single block
      from_str("abc", m);
      send(m, 8'h10, 0, 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);
      // R3 known answer, 56 bytes forces spill block
      from_str("abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", m);
      send(m, 8'h11, 1, 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1);
      // R3 boundary lengths
      from_seed(1, 3, m);   send(m, 8'h20, 0, model(m));
      from_seed(55, 5, m);  send(m, 8'h21, 0, model(m));
      from_seed(63, 9, m);  send(m, 8'h22, 2, model(m));
      from_seed(64, 11, m); send(m, 8'h23, 0, model(m));
      // R9 multi-block, back to back so the next block meets the final round
      from_seed(65, 13, m);  send(m, 8'h24, 0, model(m));
      from_seed(119, 17, m); send(m, 8'h25, 0, model(m));
      from_seed(120, 19, m); send(m, 8'h26, 0, model(m));
      from_seed(128, 23, m); send(m, 8'h27, 0, model(m));
      // R1 same content with and without idle cycles
      from_seed(200, 29, m2);
      send(m2, 8'h30, 0, model(m2));
      send(m2, 8'h31, 3, model(m2));

      begin
         int w = 0;
         while (q_sha.size() != 0 && w < 3000) begin @(negedge clk); w++; end
      end
      repeat (5) @(negedge clk);
      chk(got == sent, "R2 one digest per message", 256'(got), 256'(sent));
      finish_up();
   end

endmodule